// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block sits beside the ECC checker of a DRAM controller and keeps a software-visible record of memory errors. The checker sends a one-cycle pulse for each corrected (single-bit) error and each uncorrected (multi-bit) error, with the failing address. The block counts both classes in saturating counters. It keeps one address for each class: the first uncorrected address and the latest corrected address. A level interrupt is raised while it is enabled and either counter is nonzero.

Software reaches the block through a simple 32-bit register bus with a write strobe, a byte offset and combinational read data. Every register except the key register is write-protected. Writing a magic key value opens the protection and writing the key's complement closes it again. To acknowledge errors, software sets a clear bit, which empties both counters and drops the interrupt, and then writes the bit back to zero so that counting resumes. A configuration register holds an ECC-enable bit and a DRAM-type bit. It only stores them for software and does not control the memory controller.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, the block is locked (offset 0x00 reads 0), the configuration register (0x04) reads 0, the control/status register (0x50) reads 0, both address registers (0x58, 0x5C) read 0, and `irq` is low.
- R2: A write of 0xFC600309 to offset 0x00 unlocks the block, and a write of 0x039FFCF6 to offset 0x00 locks it. A write of any other value to 0x00 leaves the lock state unchanged. Offset 0x00 reads 1 in bit 0 while unlocked and 0 while locked, with all other bits 0.
- R3: While the block is locked, writes to offsets 0x04 and 0x50 have no effect.
- R4: While the block is unlocked, a write to 0x04 stores all 32 bits (bit 7 = ECC on, bit 4 = DRAM type, 1 for DDR4 and 0 for DDR3). The stored value reads back whether the block is locked or not.
- R5: Each corrected-error pulse adds one to the corrected count in bits 23:16 of 0x50. The count stops at 255 and does not wrap.
- R6: Each uncorrected-error pulse adds one to the uncorrected count in bits 15:12 of 0x50. The count stops at 15 and does not wrap.
- R7: Offset 0x58 holds the address of the first uncorrected error. Later uncorrected errors leave it unchanged.
- R8: Every corrected error overwrites offset 0x5C with its address.
- R9: `irq` is high exactly when the enable field (bits 1:0 of 0x50) is nonzero and at least one count is nonzero.
- R10: Bit 31 of 0x50 is the clear control and reads back as written. While it is 1, both counts are held at 0, error pulses are discarded (no count, no address update), and the first-error capture is re-armed. After it is written back to 0, the next uncorrected error is latched as a new first address.
- R11: Offsets other than 0x00, 0x04, 0x50, 0x58 and 0x5C read 0, and writes to them have no effect. Bits 30:24 and 11:2 of 0x50 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_hit | input | 1 | One-cycle pulse for a corrected error |
| ce_addr | input | ADDR_W | Address of the corrected error |
| ue_hit | input | 1 | One-cycle pulse for an uncorrected error |
| ue_addr | input | ADDR_W | Address of the uncorrected error |
| bus_wr | input | 1 | Register write strobe |
| bus_off | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_off` (combinational) |
| irq | output | 1 | Active-high level interrupt |

## Verification
Two things can land on the same clock edge: an error pulse and the clear control, or an error pulse and a register write. In both cases the question is which one wins. The bench holds the clear bit high while it sends both kinds of pulse, and it also writes the clear bit on the same cycle as a pulse. The expected results come from a cycle model that applies each pulse against the clear value that was registered before that edge. The random phase then mixes pulses, key writes, locked and unlocked writes and clears. Every cycle it compares one register read and the interrupt line against the model.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
   localparam int OFF_W = 8;
   localparam int DATA_W = 32;

   localparam logic [OFF_W-1:0] OFF_KEY  = 8'h00;
   localparam logic [OFF_W-1:0] OFF_CFG  = 8'h04;
   localparam logic [OFF_W-1:0] OFF_CTRL = 8'h50;
   localparam logic [OFF_W-1:0] OFF_UEA  = 8'h58;
   localparam logic [OFF_W-1:0] OFF_CEA  = 8'h5C;

   localparam logic [DATA_W-1:0] UNLOCK_WORD = 32'hFC60_0309;

   localparam int CLR_POS   = 31;
   localparam int CE_LSB    = 16;
   localparam int CE_FIELD  = 8;
   localparam int UE_LSB    = 12;
   localparam int UE_FIELD  = 4;
   localparam int EN_W      = 2;
endpackage

// File: rtl/ecc_log_keylock.sv
module ecc_log_keylock #(
   parameter int             DW  = 32,
   parameter logic [DW-1:0]  KEY = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          key_wr,
   input  logic [DW-1:0] key_val,
   output logic          open_q
);
   localparam logic [DW-1:0] RELOCK = ~KEY;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
      end else if (key_wr) begin
         if (key_val == KEY)
            open_q <= 1'b1;
         else if (key_val == RELOCK)
            open_q <= 1'b0;
      end
   end

   // R2: lock state moves only on a key write
   assert_lock_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !key_wr |=> $stable(open_q));
   // R2: a wrong value never changes the lock
   assert_lock_junk_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && key_val != KEY && key_val != RELOCK) |=> $stable(open_q));
endmodule

// File: rtl/ecc_log_satcnt.sv
module ecc_log_satcnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt_q
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   if (W < 1) begin : g_bad_width
      $error("ecc_log_satcnt: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (inc && cnt_q != TOP)
         cnt_q <= cnt_q + 1'b1;
   end

   // R5 / R6: full counter stays full
   assert_cnt_sat_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt_q == TOP) |=> cnt_q == TOP);
   // R5 / R6: below the top, one step per event
   assert_cnt_step_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1);
   // R10: clear empties the counter
   assert_cnt_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt_q == '0);
endmodule

// File: rtl/ecc_log_addrcap.sv
module ecc_log_addrcap #(
   parameter int AW         = 32,
   parameter bit KEEP_FIRST = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          hit,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_q
);
   if (KEEP_FIRST) begin : g_first
      logic held_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held_q <= 1'b0;
            addr_q <= '0;
         end else if (clr) begin
            held_q <= 1'b0;
         end else if (hit && !held_q) begin
            held_q <= 1'b1;
            addr_q <= addr_in;
         end
      end
      // R7: once an address is held, later events leave it
      assert_first_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (held_q && !clr) |=> $stable(addr_q));
   end else begin : g_last
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            addr_q <= '0;
         else if (hit && !clr)
            addr_q <= addr_in;
      end
      // R8: every accepted event lands its address
      assert_last_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && !clr) |=> addr_q == $past(addr_in));
   end

   // R10: events during clear are discarded
   assert_clr_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> $stable(addr_q));
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
   import ecc_log_pkg::*;
#(
   parameter int             ADDR_W    = 32,
   parameter int             CE_CNT_W  = 8,
   parameter int             UE_CNT_W  = 4,
   parameter logic [31:0]    KEY       = UNLOCK_WORD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_hit,
   input  logic [ADDR_W-1:0] ce_addr,
   input  logic              ue_hit,
   input  logic [ADDR_W-1:0] ue_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_off,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_aw
      $error("ecc_err_log: ADDR_W must be 1..32");
   end
   if (CE_CNT_W < 1 || CE_CNT_W > CE_FIELD) begin : g_bad_ce
      $error("ecc_err_log: CE_CNT_W exceeds its field");
   end
   if (UE_CNT_W < 1 || UE_CNT_W > UE_FIELD) begin : g_bad_ue
      $error("ecc_err_log: UE_CNT_W exceeds its field");
   end

   logic                unlocked;
   logic [DATA_W-1:0]   cfg_q;
   logic [EN_W-1:0]     en_q;
   logic                clr_q;
   logic [CE_CNT_W-1:0] ce_cnt;
   logic [UE_CNT_W-1:0] ue_cnt;
   logic [ADDR_W-1:0]   ce_addr_q;
   logic [ADDR_W-1:0]   ue_addr_q;
   logic                wr_key, wr_cfg, wr_ctrl;

   assign wr_key  = bus_wr && (bus_off == OFF_KEY);
   assign wr_cfg  = bus_wr && unlocked && (bus_off == OFF_CFG);
   assign wr_ctrl = bus_wr && unlocked && (bus_off == OFF_CTRL);

   ecc_log_keylock #(.DW(DATA_W), .KEY(KEY)) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .key_wr  (wr_key),
      .key_val (bus_wdata),
      .open_q  (unlocked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         en_q  <= '0;
         clr_q <= 1'b0;
      end else begin
         if (wr_cfg)
            cfg_q <= bus_wdata;
         if (wr_ctrl) begin
            en_q  <= bus_wdata[EN_W-1:0];
            clr_q <= bus_wdata[CLR_POS];
         end
      end
   end

   ecc_log_satcnt #(.W(CE_CNT_W)) u_ce_cnt (
      .clk (clk), .rst_n (rst_n), .clr (clr_q), .inc (ce_hit), .cnt_q (ce_cnt)
   );
   ecc_log_satcnt #(.W(UE_CNT_W)) u_ue_cnt (
      .clk (clk), .rst_n (rst_n), .clr (clr_q), .inc (ue_hit), .cnt_q (ue_cnt)
   );

   ecc_log_addrcap #(.AW(ADDR_W), .KEEP_FIRST(1'b0)) u_ce_addr (
      .clk (clk), .rst_n (rst_n), .clr (clr_q), .hit (ce_hit),
      .addr_in (ce_addr), .addr_q (ce_addr_q)
   );
   ecc_log_addrcap #(.AW(ADDR_W), .KEEP_FIRST(1'b1)) u_ue_addr (
      .clk (clk), .rst_n (rst_n), .clr (clr_q), .hit (ue_hit),
      .addr_in (ue_addr), .addr_q (ue_addr_q)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (bus_off)
         OFF_KEY:  bus_rdata[0] = unlocked;
         OFF_CFG:  bus_rdata = cfg_q;
         OFF_CTRL: begin
            bus_rdata[CLR_POS]               = clr_q;
            bus_rdata[CE_LSB +: CE_CNT_W]    = ce_cnt;
            bus_rdata[UE_LSB +: UE_CNT_W]    = ue_cnt;
            bus_rdata[EN_W-1:0]              = en_q;
         end
         OFF_UEA:  bus_rdata[ADDR_W-1:0] = ue_addr_q;
         OFF_CEA:  bus_rdata[ADDR_W-1:0] = ce_addr_q;
         default:  bus_rdata = '0;
      endcase
   end

   assign irq = (|en_q) && ((|ce_cnt) || (|ue_cnt));

   // R3: locked writes leave configuration and control alone
   assert_locked_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !unlocked && bus_off == OFF_CFG) |=> $stable(cfg_q));
   assert_locked_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !unlocked && bus_off == OFF_CTRL) |=> ($stable(en_q) && $stable(clr_q)));
   // R9, R10: a held clear keeps the interrupt low
   assert_clr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_q && $past(clr_q)) |-> !irq);
endmodule

// File: tb/tb_ecc_err_log.sv
`timescale 1ns/1ps
module tb_ecc_err_log;
   localparam logic [31:0] KEYV = 32'hFC60_0309;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_hit = 1'b0, ue_hit = 1'b0;
   logic [31:0] ce_addr = '0, ue_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_off = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   ecc_err_log dut (
      .clk (clk), .rst_n (rst_n),
      .ce_hit (ce_hit), .ce_addr (ce_addr),
      .ue_hit (ue_hit), .ue_addr (ue_addr),
      .bus_wr (bus_wr), .bus_off (bus_off), .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata), .irq (irq)
   );

   // reference model state
   logic        m_open = 0, m_clr = 0, m_held = 0;
   logic [31:0] m_cfg = 0, m_uea = 0, m_cea = 0;
   logic [1:0]  m_en = 0;
   int          m_ce = 0, m_ue = 0;

   function automatic logic [31:0] exp_read(input logic [7:0] off);
      logic [31:0] v = '0;
      case (off)
         8'h00: v[0] = m_open;
         8'h04: v = m_cfg;
         8'h50: begin
            v[31] = m_clr; v[23:16] = 8'(m_ce); v[15:12] = 4'(m_ue); v[1:0] = m_en;
         end
         8'h58: v = m_uea;
         8'h5C: v = m_cea;
         default: v = '0;
      endcase
      return v;
   endfunction

   function automatic logic exp_irq();
      return (m_en != 0) && (m_ce != 0 || m_ue != 0);
   endfunction

   function automatic string tag_of(input logic [7:0] off);
      case (off)
         8'h00: return "R2 key";
         8'h04: return "R4 cfg";
         8'h50: return "R5 R6 R10 ctrl";
         8'h58: return "R7 ue addr";
         8'h5C: return "R8 ce addr";
         default: return "R11 unmapped";
      endcase
   endfunction

   task automatic chk(input string lbl, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", lbl, act, exp);
      end
   endtask

   task automatic model_step(input logic wr, input logic [7:0] off, input logic [31:0] wd,
                             input logic ce, input logic [31:0] ca,
                             input logic ue, input logic [31:0] ua);
      if (m_clr) begin
         m_ce = 0; m_ue = 0; m_held = 0;
      end else begin
         if (ce) begin
            if (m_ce < 255) m_ce++;
            m_cea = ca;
         end
         if (ue) begin
            if (m_ue < 15) m_ue++;
            if (!m_held) begin m_uea = ua; m_held = 1; end
         end
      end
      if (wr) begin
         if (off == 8'h00) begin
            if (wd == KEYV) m_open = 1;
            else if (wd == ~KEYV) m_open = 0;
         end else if (m_open && off == 8'h04) begin
            m_cfg = wd;
         end else if (m_open && off == 8'h50) begin
            m_en = wd[1:0]; m_clr = wd[31];
         end
      end
   endtask

   // one clock: drive at the falling edge, check at the next falling edge
   task automatic cyc(input logic wr, input logic [7:0] off, input logic [31:0] wd,
                      input logic ce, input logic [31:0] ca,
                      input logic ue, input logic [31:0] ua, input logic [7:0] roff);
      bus_wr = wr; bus_off = off; bus_wdata = wd;
      ce_hit = ce; ce_addr = ca; ue_hit = ue; ue_addr = ua;
      model_step(wr, off, wd, ce, ca, ue, ua);
      @(posedge clk); #1;
      bus_wr = 0; ce_hit = 0; ue_hit = 0; bus_off = roff;
      @(negedge clk);
      chk(tag_of(roff), bus_rdata, exp_read(roff));
      chk("R9 irq", {31'b0, irq}, {31'b0, exp_irq()});
   endtask

   task automatic wr_reg(input logic [7:0] off, input logic [31:0] wd, input logic [7:0] roff);
      cyc(1, off, wd, 0, 0, 0, 0, roff);
   endtask

   task automatic idle_rd(input logic [7:0] roff);
      cyc(0, 8'h00, 0, 0, 0, 0, 0, roff);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [7:0] offs [6];
      offs[0] = 8'h00; offs[1] = 8'h04; offs[2] = 8'h50;
      offs[3] = 8'h58; offs[4] = 8'h5C; offs[5] = 8'h10;
      void'($urandom(32'd4242));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state on every register and the interrupt
      for (int i = 0; i < 6; i++) begin
         bus_off = offs[i]; #0.5;
         chk("R1 reset", bus_rdata, 32'h0);
      end
      chk("R1 irq", {31'b0, irq}, 32'h0);

      // R3: locked writes ignored
      wr_reg(8'h04, 32'hFFFF_FFFF, 8'h04);
      wr_reg(8'h50, 32'h0000_0003, 8'h50);
      // R2: junk key keeps lock, real key opens
      wr_reg(8'h00, 32'h1234_5678, 8'h00);
      wr_reg(8'h00, KEYV, 8'h00);
      // R4: config stores and stays readable after relock
      wr_reg(8'h04, 32'h0000_0090, 8'h04);
      wr_reg(8'h00, ~KEYV, 8'h00);
      idle_rd(8'h04);
      wr_reg(8'h04, 32'h0000_0000, 8'h04);   // R3 locked
      wr_reg(8'h00, KEYV, 8'h00);
      // R11: unmapped write has no effect
      wr_reg(8'h10, 32'hDEAD_BEEF, 8'h10);
      wr_reg(8'h50, 32'h0000_0003, 8'h50);
      // R8, R9: corrected errors, last address kept
      cyc(0, 0, 0, 1, 32'h0000_1000, 0, 0, 8'h5C);
      cyc(0, 0, 0, 1, 32'h0000_2000, 0, 0, 8'h5C);
      // R7: first uncorrected address kept
      cyc(0, 0, 0, 0, 0, 1, 32'hAAAA_0000, 8'h58);
      cyc(0, 0, 0, 0, 0, 1, 32'hBBBB_0000, 8'h58);
      // R5: saturate corrected count
      for (int i = 0; i < 300; i++) cyc(0, 0, 0, 1, 32'(i), 0, 0, 8'h50);
      // R6: saturate uncorrected count
      for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 0, 1, 32'(i + 7), 8'h50);
      // R10: clear written together with pulses, then pulses while held
      cyc(1, 8'h50, 32'h8000_0003, 1, 32'h0000_0C0C, 1, 32'h0000_0E0E, 8'h50);
      cyc(0, 0, 0, 1, 32'h0000_0F0F, 1, 32'h0000_0D0D, 8'h5C);
      cyc(0, 0, 0, 1, 32'h0000_0F1F, 1, 32'h0000_0D1D, 8'h58);
      idle_rd(8'h50);
      wr_reg(8'h50, 32'h0000_0003, 8'h50);
      cyc(0, 0, 0, 0, 0, 1, 32'h0000_C0DE, 8'h58);
      cyc(0, 0, 0, 0, 0, 1, 32'h0000_F00D, 8'h58);
      // R9: enables off hides nonzero counts
      wr_reg(8'h50, 32'h0000_0000, 8'h50);
      wr_reg(8'h50, 32'h0000_0002, 8'h50);

      // random mix
      for (int n = 0; n < 4000; n++) begin
         logic wr; logic [7:0] off; logic [31:0] wd; int r;
         wr = ($urandom % 100) < 20;
         r = $urandom % 10;
         off = (r < 3) ? 8'h00 : (r < 5) ? 8'h04 : (r < 9) ? 8'h50 : 8'h10;
         wd = $urandom;
         if (off == 8'h00) begin
            r = $urandom % 3;
            wd = (r == 0) ? KEYV : (r == 1) ? ~KEYV : wd;
         end
         if (off == 8'h50) wd[31] = (($urandom % 100) < 15);
         cyc(wr, off, wd,
             ($urandom % 100) < 40, $urandom,
             ($urandom % 100) < 12, $urandom,
             offs[$urandom % 6]);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule